// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block turns pacer ticks and software strobes into single-cycle convert commands for an analog-to-digital converter. Five modes are supported: single software-commanded conversions, free-running pacing, and three modes that are gated by an external trigger. The post-trigger mode waits for the trigger and then takes a fixed number of samples. The pre-trigger mode samples from the arming strobe until the trigger arrives. The middle-trigger mode samples until the trigger and then takes a fixed number of further samples before it stops. The block counts the conversions it issues and reports status for end of conversion, trigger level and middle-trigger completion.

The mode is loaded in two steps, matching a 16-bit command register that is written as two bytes. A high-byte write stages the mode. The low-byte write that follows it makes the staged mode active. Separate write-any-value strobes arm and abort acquisition. The pacer divider, the converter itself and the sample store all lie outside the block. A single pacer tick input, a conversion-finished input and the convert output connect it to them. Every interface is a plain strobe or level, because no data stream passes through the block.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: The mode loaded through `cmd_hi_mode` on a `cmd_hi_wr` cycle becomes active only on a later `cmd_lo_wr`. A `cmd_lo_wr` with no `cmd_hi_wr` since the previous commit leaves the mode unchanged. The reset mode is 000. Mode codes are 000 pacer, 001 post-trigger, 010 pre-trigger, 011 middle-trigger and 100 polling.
- R2: In polling mode, each `sw_conv_wr` pulse gives exactly one `conv_start` pulse, in the following cycle, whether or not acquisition is armed. `sw_conv_wr` has no effect in any other mode.
- R3: `conv_ready` is 0 after reset. A polling conversion clears it, and a `conv_done` pulse sets it to 1.
- R4: In pacer mode, after `enable_wr`, every `pacer_tick` gives one `conv_start` in the next cycle. No conversions occur after `disable_wr`.
- R5: `enable_wr` arms acquisition in the pacer, post-trigger, pre-trigger and middle-trigger modes and raises `acq_active`. `disable_wr` or a mode commit drops `acq_active` in the next cycle. `disable_wr` wins when it arrives together with `enable_wr`.
- R6: In post-trigger mode, no conversion occurs before the first synchronized rising edge of `ext_trig`. After that edge, exactly `n_after` conversions occur, and then `acq_active` falls.
- R7: In pre-trigger mode, conversions run from `enable_wr` until the trigger edge and then stop. `pre_window_full` reads 1 once at least `n_before` samples have been taken.
- R8: In middle-trigger mode, the block samples before the trigger as in R7 with `n_before`. After the trigger edge it takes exactly `n_after` more samples, then stops and sets `mid_end` to 1.
- R9: `mid_end` is 0 after reset and is cleared by `enable_wr` or by a mode commit.
- R10: `trig_active` follows the level of `ext_trig` through a two-flop synchronizer.
- R11: Only the first rising trigger edge after `enable_wr` has an effect. An edge seen before arming, or a second edge during the same acquisition, is ignored.
- R12: Mode codes 101, 110 and 111 produce no conversions and leave `acq_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_hi_wr | input | 1 | High-byte command write strobe; stages the mode |
| cmd_hi_mode | input | 3 | Mode bits carried by the high-byte write |
| cmd_lo_wr | input | 1 | Low-byte command write strobe; commits the staged mode |
| sw_conv_wr | input | 1 | Software convert strobe (polling mode) |
| enable_wr | input | 1 | Arm acquisition strobe |
| disable_wr | input | 1 | Abort acquisition strobe |
| pacer_tick | input | 1 | One-cycle tick from the pacer divider |
| ext_trig | input | 1 | Asynchronous external trigger level |
| n_before | input | CNT_W | Sample count before the trigger (pre and middle modes) |
| n_after | input | CNT_W | Sample count after the trigger (post and middle modes) |
| conv_done | input | 1 | Converter finished pulse |
| conv_start | output | 1 | One-cycle convert command |
| acq_active | output | 1 | Acquisition armed or running |
| conv_ready | output | 1 | End-of-conversion status |
| trig_active | output | 1 | Synchronized trigger level status |
| mid_end | output | 1 | Middle-trigger acquisition complete |
| pre_window_full | output | 1 | At least `n_before` pre-trigger samples taken |

## Verification
The assertions assume that `pacer_tick`, `sw_conv_wr` and the command strobes are single-cycle pulses. They also assume that `n_before` and `n_after` stay constant while an acquisition runs and that `ext_trig` is low during reset. The stimulus changes inputs only at the falling clock edge and spaces the ticks two cycles apart. It changes the counts only while the block is idle, and it holds every trigger level for several cycles so that the synchronizer sees each edge.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam logic [2:0] MODE_PACER = 3'b000;
  localparam logic [2:0] MODE_POST  = 3'b001;
  localparam logic [2:0] MODE_PRE   = 3'b010;
  localparam logic [2:0] MODE_MID   = 3'b011;
  localparam logic [2:0] MODE_POLL  = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREE,
    ST_WAIT_TRIG,
    ST_BEFORE,
    ST_AFTER
  } acq_state_t;
endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              level_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~level_d;
endmodule

// File: rtl/acq_cmd_latch.sv
module acq_cmd_latch
  import acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_wr,
  input  logic [2:0] hi_mode,
  input  logic       lo_wr,
  output logic [2:0] mode,
  output logic       commit
);
  logic [2:0] staged_q;
  logic       pending_q;

  assign commit = lo_wr & pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q  <= MODE_PACER;
      pending_q <= 1'b0;
      mode      <= MODE_PACER;
    end else begin
      if (commit) begin
        mode      <= staged_q;
        pending_q <= 1'b0;
      end
      if (hi_wr) begin
        staged_q  <= hi_mode;
        pending_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/acq_sample_counter.sv
module acq_sample_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         reached
);
  logic [W-1:0] count_q;

  assign reached = (count_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)               count_q <= '0;
    else if (clr)             count_q <= '0;
    else if (inc && !reached) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/acq_mode_fsm.sv
module acq_mode_fsm
  import acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       commit,
  input  logic       enable_wr,
  input  logic       disable_wr,
  input  logic       pacer_tick,
  input  logic       sw_conv_wr,
  input  logic       trig_rise,
  input  logic       after_hit,
  output acq_state_t state,
  output logic       issue,
  output logic       before_inc,
  output logic       after_inc,
  output logic       mid_finish
);
  acq_state_t next_state;
  logic       poll_issue;
  logic       paced_issue;

  assign poll_issue = sw_conv_wr && (mode == MODE_POLL);

  always_comb begin
    paced_issue = 1'b0;
    case (state)
      ST_FREE, ST_BEFORE: paced_issue = pacer_tick;
      ST_AFTER:           paced_issue = pacer_tick && !after_hit;
      default:            paced_issue = 1'b0;
    endcase
  end

  assign issue      = poll_issue | paced_issue;
  assign before_inc = paced_issue && (state == ST_BEFORE);
  assign after_inc  = paced_issue && (state == ST_AFTER);
  assign mid_finish = (state == ST_AFTER) && after_hit && (mode == MODE_MID)
                      && !disable_wr && !commit && !enable_wr;

  always_comb begin
    next_state = state;
    if (disable_wr || commit) begin
      next_state = ST_IDLE;
    end else if (enable_wr) begin
      case (mode)
        MODE_PACER:         next_state = ST_FREE;
        MODE_POST:          next_state = ST_WAIT_TRIG;
        MODE_PRE, MODE_MID: next_state = ST_BEFORE;
        default:            next_state = ST_IDLE;
      endcase
    end else begin
      case (state)
        ST_WAIT_TRIG: if (trig_rise) next_state = ST_AFTER;
        ST_BEFORE:    if (trig_rise) next_state = (mode == MODE_MID) ? ST_AFTER : ST_IDLE;
        ST_AFTER:     if (after_hit) next_state = ST_IDLE;
        default:      next_state = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= next_state;
  end
endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hi_wr,
  input  logic [2:0]       cmd_hi_mode,
  input  logic             cmd_lo_wr,
  input  logic             sw_conv_wr,
  input  logic             enable_wr,
  input  logic             disable_wr,
  input  logic             pacer_tick,
  input  logic             ext_trig,
  input  logic [CNT_W-1:0] n_before,
  input  logic [CNT_W-1:0] n_after,
  input  logic             conv_done,
  output logic             conv_start,
  output logic             acq_active,
  output logic             conv_ready,
  output logic             trig_active,
  output logic             mid_end,
  output logic             pre_window_full
);
  logic [2:0]  mode_q;
  logic        commit;
  logic        trig_rise;
  logic        issue;
  logic        before_inc;
  logic        after_inc;
  logic        after_hit;
  logic        mid_finish;
  acq_state_t  fsm_state;
  logic        conv_start_q;
  logic        ready_q;
  logic        mid_end_q;

  acq_cmd_latch u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_wr   (cmd_hi_wr),
    .hi_mode (cmd_hi_mode),
    .lo_wr   (cmd_lo_wr),
    .mode    (mode_q),
    .commit  (commit)
  );

  acq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_trig),
    .level    (trig_active),
    .rise     (trig_rise)
  );

  acq_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .commit     (commit),
    .enable_wr  (enable_wr),
    .disable_wr (disable_wr),
    .pacer_tick (pacer_tick),
    .sw_conv_wr (sw_conv_wr),
    .trig_rise  (trig_rise),
    .after_hit  (after_hit),
    .state      (fsm_state),
    .issue      (issue),
    .before_inc (before_inc),
    .after_inc  (after_inc),
    .mid_finish (mid_finish)
  );

  acq_sample_counter #(.W(CNT_W)) u_before_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (enable_wr),
    .inc     (before_inc),
    .limit   (n_before),
    .reached (pre_window_full)
  );

  acq_sample_counter #(.W(CNT_W)) u_after_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (enable_wr),
    .inc     (after_inc),
    .limit   (n_after),
    .reached (after_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start_q <= 1'b0;
      ready_q      <= 1'b0;
      mid_end_q    <= 1'b0;
    end else begin
      conv_start_q <= issue;
      if (sw_conv_wr && mode_q == MODE_POLL) ready_q <= 1'b0;
      else if (conv_done)                    ready_q <= 1'b1;
      if (enable_wr || commit) mid_end_q <= 1'b0;
      else if (mid_finish)     mid_end_q <= 1'b1;
    end
  end

  assign conv_start = conv_start_q;
  assign conv_ready = ready_q;
  assign mid_end    = mid_end_q;
  assign acq_active = (fsm_state != ST_IDLE);
endmodule

// File: rtl/acq_trigger_ctrl_chk.sv
module acq_trigger_ctrl_chk
  import acq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input acq_state_t state,
  input logic       pacer_tick,
  input logic       sw_conv_wr,
  input logic       disable_wr,
  input logic       conv_done,
  input logic       ext_trig,
  input logic       conv_start,
  input logic       acq_active,
  input logic       conv_ready,
  input logic       trig_active,
  input logic       mid_end
);
  // R2 / R4: every convert command has a tick or a software strobe behind it
  assert_conv_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(pacer_tick || sw_conv_wr));

  // R2: a software strobe in polling mode always converts
  assert_poll_converts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_conv_wr && mode == MODE_POLL) |=> conv_start);

  // R3: ready only rises after the converter reports completion
  assert_ready_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_ready) |-> $past(conv_done));

  // R5: abort drops the active flag
  assert_disable_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disable_wr |=> !acq_active);

  // R6: nothing is converted while waiting for the post trigger
  assert_post_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_TRIG && !sw_conv_wr) |=> !conv_start);

  // R8: completion flag only rises in middle-trigger mode
  assert_mid_end_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mid_end) |-> ($past(mode) == MODE_MID));

  // R10: trigger status follows the input level
  assert_trig_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_active) |-> $past(ext_trig));

  // R12: reserved codes never convert
  assert_reserved_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(mode) <= MODE_POLL));
endmodule

bind acq_trigger_ctrl acq_trigger_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode_q),
  .state       (fsm_state),
  .pacer_tick  (pacer_tick),
  .sw_conv_wr  (sw_conv_wr),
  .disable_wr  (disable_wr),
  .conv_done   (conv_done),
  .ext_trig    (ext_trig),
  .conv_start  (conv_start),
  .acq_active  (acq_active),
  .conv_ready  (conv_ready),
  .trig_active (trig_active),
  .mid_end     (mid_end)
);

// File: tb/acq_trigger_ctrl_test.sv
module acq_trigger_ctrl_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_hi_wr = 1'b0;
  logic [2:0]       cmd_hi_mode = 3'b000;
  logic             cmd_lo_wr = 1'b0;
  logic             sw_conv_wr = 1'b0;
  logic             enable_wr = 1'b0;
  logic             disable_wr = 1'b0;
  logic             pacer_tick = 1'b0;
  logic             ext_trig = 1'b0;
  logic [CNT_W-1:0] n_before = '0;
  logic [CNT_W-1:0] n_after = '0;
  logic             conv_done = 1'b0;
  logic             conv_start;
  logic             acq_active;
  logic             conv_ready;
  logic             trig_active;
  logic             mid_end;
  logic             pre_window_full;

  int checks = 0;
  int errors = 0;
  int conv_cnt = 0;
  bit finished = 1'b0;

  acq_trigger_ctrl #(.CNT_W(CNT_W)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_hi_wr       (cmd_hi_wr),
    .cmd_hi_mode     (cmd_hi_mode),
    .cmd_lo_wr       (cmd_lo_wr),
    .sw_conv_wr      (sw_conv_wr),
    .enable_wr       (enable_wr),
    .disable_wr      (disable_wr),
    .pacer_tick      (pacer_tick),
    .ext_trig        (ext_trig),
    .n_before        (n_before),
    .n_after         (n_after),
    .conv_done       (conv_done),
    .conv_start      (conv_start),
    .acq_active      (acq_active),
    .conv_ready      (conv_ready),
    .trig_active     (trig_active),
    .mid_end         (mid_end),
    .pre_window_full (pre_window_full)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && conv_start) conv_cnt++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_hi(input logic [2:0] m);
    @(negedge clk); cmd_hi_wr = 1'b1; cmd_hi_mode = m;
    @(negedge clk); cmd_hi_wr = 1'b0;
  endtask

  task automatic pulse_lo();
    @(negedge clk); cmd_lo_wr = 1'b1;
    @(negedge clk); cmd_lo_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    pulse_hi(m);
    pulse_lo();
  endtask

  task automatic do_enable();
    @(negedge clk); enable_wr = 1'b1;
    @(negedge clk); enable_wr = 1'b0;
  endtask

  task automatic do_disable();
    @(negedge clk); disable_wr = 1'b1;
    @(negedge clk); disable_wr = 1'b0;
  endtask

  task automatic do_sw();
    @(negedge clk); sw_conv_wr = 1'b1;
    @(negedge clk); sw_conv_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pacer_tick = 1'b1;
      @(negedge clk); pacer_tick = 1'b0;
    end
    idle(2);
  endtask

  task automatic set_trig(input logic v);
    @(negedge clk); ext_trig = v;
    idle(4);
  endtask

  task automatic test_reset();
    chk("R5", "acq_active after reset", acq_active, 0);
    chk("R3", "conv_ready after reset", conv_ready, 0);
    chk("R9", "mid_end after reset", mid_end, 0);
    chk("R10", "trig_active after reset", trig_active, 0);
    chk("R4", "conv_start after reset", conv_start, 0);
  endtask

  task automatic test_mode_commit();
    int base;
    pulse_hi(3'b100);
    base = conv_cnt; do_sw(); idle(2);
    chk("R1", "staged mode not yet active", conv_cnt - base, 0);
    pulse_lo();
    base = conv_cnt; do_sw(); idle(2);
    chk("R1", "committed polling converts", conv_cnt - base, 1);
    pulse_lo();
    base = conv_cnt; do_sw(); idle(2);
    chk("R1", "lone low write keeps mode", conv_cnt - base, 1);
  endtask

  task automatic test_polling();
    int base;
    base = conv_cnt; do_sw(); do_sw(); do_sw(); idle(2);
    chk("R2", "one start per strobe", conv_cnt - base, 3);
    chk("R2", "polling needs no arming", acq_active, 0);
    chk("R3", "ready cleared by conversion", conv_ready, 0);
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    chk("R3", "ready set by done", conv_ready, 1);
    do_sw(); idle(1);
    chk("R3", "ready cleared by next conversion", conv_ready, 0);
  endtask

  task automatic test_pacer();
    int base;
    set_mode(3'b000);
    base = conv_cnt; do_sw(); idle(2);
    chk("R2", "strobe ignored outside polling", conv_cnt - base, 0);
    base = conv_cnt; ticks(2);
    chk("R4", "no pacing before arming", conv_cnt - base, 0);
    do_enable();
    chk("R5", "active after enable", acq_active, 1);
    base = conv_cnt; ticks(5);
    chk("R4", "one start per tick", conv_cnt - base, 5);
    do_disable();
    chk("R5", "inactive after disable", acq_active, 0);
    base = conv_cnt; ticks(3);
    chk("R4", "no starts after disable", conv_cnt - base, 0);
    @(negedge clk); enable_wr = 1'b1; disable_wr = 1'b1;
    @(negedge clk); enable_wr = 1'b0; disable_wr = 1'b0;
    chk("R5", "disable wins over enable", acq_active, 0);
  endtask

  task automatic test_post();
    int base;
    n_after = 16'd4;
    set_mode(3'b001);
    do_enable();
    base = conv_cnt; ticks(3);
    chk("R6", "no conversion before trigger", conv_cnt - base, 0);
    chk("R6", "waiting while armed", acq_active, 1);
    set_trig(1'b1);
    chk("R10", "trig_active follows high", trig_active, 1);
    base = conv_cnt; ticks(6);
    chk("R6", "n_after conversions after trigger", conv_cnt - base, 4);
    chk("R6", "stopped after count", acq_active, 0);
    set_trig(1'b0);
    chk("R10", "trig_active follows low", trig_active, 0);
  endtask

  task automatic test_trigger_before_arm();
    int base;
    set_trig(1'b1);
    do_enable();
    base = conv_cnt; ticks(3);
    chk("R11", "edge before arming ignored", conv_cnt - base, 0);
    chk("R11", "still waiting", acq_active, 1);
    do_disable();
    set_trig(1'b0);
  endtask

  task automatic test_pre();
    int base;
    n_before = 16'd3;
    set_mode(3'b010);
    do_enable();
    base = conv_cnt; ticks(2);
    chk("R7", "runs from enable", conv_cnt - base, 2);
    chk("R7", "window not yet full", pre_window_full, 0);
    ticks(3);
    chk("R7", "keeps running past window", conv_cnt - base, 5);
    chk("R7", "window full", pre_window_full, 1);
    set_trig(1'b1);
    chk("R7", "stopped at trigger", acq_active, 0);
    base = conv_cnt; ticks(2);
    chk("R7", "no conversion after trigger", conv_cnt - base, 0);
    set_trig(1'b0);
  endtask

  task automatic test_middle();
    int base;
    n_before = 16'd2;
    n_after  = 16'd3;
    set_mode(3'b011);
    do_enable();
    base = conv_cnt; ticks(4);
    chk("R8", "before phase converts", conv_cnt - base, 4);
    set_trig(1'b1);
    chk("R8", "mid_end low in after phase", mid_end, 0);
    set_trig(1'b0);
    ticks(1);
    set_trig(1'b1);
    chk("R11", "second edge keeps acquisition", acq_active, 1);
    ticks(4);
    chk("R8", "n_after further conversions", conv_cnt - base, 7);
    chk("R8", "mid_end set at completion", mid_end, 1);
    chk("R8", "stopped after completion", acq_active, 0);
    set_trig(1'b0);
    do_enable();
    chk("R9", "enable clears mid_end", mid_end, 0);
    do_disable();
  endtask

  task automatic test_reserved();
    int base;
    set_mode(3'b101);
    do_enable();
    chk("R12", "reserved code not armed", acq_active, 0);
    base = conv_cnt; ticks(3); do_sw(); idle(2);
    chk("R12", "reserved code no conversions", conv_cnt - base, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    test_reset();
    test_mode_commit();
    test_polling();
    test_pacer();
    test_post();
    test_trigger_before_arm();
    test_pre();
    test_middle();
    test_reserved();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule